// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is a bus-master DMA engine for a storage controller. Software places a table of two-word descriptors in host memory, programs the table address, chooses a direction and sets a start bit. The engine then works through the table one descriptor at a time. For each descriptor it fetches the buffer address, then the byte count, and then moves whole 32-bit words between that buffer and a device-side word stream until the count is used up. It stops after the descriptor whose count word carries the last-entry flag.

A single request/response port carries every memory access, both descriptor fetches and data reads or writes. Only one request is outstanding at a time. On the device side there is an outbound stream (memory to device) and an inbound stream (device to memory), both with valid/ready handshakes. There is also a device interrupt input. A three-entry byte-addressed register block holds the command, status and table pointer. An interrupt output is high while either the error flag or the interrupt flag is set.

Top module: `sgdma_engine`

## Requirements
- R1: Registers sit at byte offsets 0 (command), 2 (status) and 4 (table pointer), with values in the low bits of the data bus. Command stores only bit 0 (start) and bit 3 (direction). Pointer bits 1:0 always read 0. All three read 0 after reset.
- R2: Writing start as 1 while it reads 0 launches a walk. The first memory request goes to the table pointer (address word), the next to pointer+4 (count word), and each following descriptor is fetched 8 bytes after the previous one.
- R3: Bits 1:0 of a descriptor's address word are ignored. Bits 15:0 of its count word are the byte count, and a value of 0 means 65536 bytes. Bit 31 flags the last descriptor.
- R4: With direction 0, the engine reads words from consecutive addresses of the buffer and presents them in order on the outbound stream. A count of N bytes moves ceil(N/4) words.
- R5: With direction 1, the engine accepts inbound stream words and writes them to consecutive buffer addresses.
- R6: Status bit 0 (active) is 1 while a walk is in progress. It returns to 0 once the last descriptor's count is used up.
- R7: The device interrupt input sets status bit 2 and leaves the active bit unchanged. The interrupt output is status bit 1 OR status bit 2.
- R8: If the table ends in direction 1 while the inbound stream still offers a word, status bit 2 is set. If the table ends with the stream idle, bit 2 stays 0.
- R9: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it alone. Status bits 7:5 hold whatever software last wrote. Bits 4:3 read 0. A hardware set takes priority over a same-cycle clear.
- R10: An error response from memory sets status bit 1 and clears active. No further memory request is issued.
- R11: If start is cleared during a walk, the engine stops once any outstanding memory access has completed, or at once if it is waiting on the device. Active then clears. A later start begins again at the table pointer.
- R12: A memory request keeps its address, write flag and write data unchanged until it is acknowledged. Every memory address is a multiple of 4.
- R13: An outbound word stays valid with unchanged data until it is accepted, unless start is cleared. The outbound valid and the inbound ready are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory response, one cycle |
| mem_err | input | 1 | Error flag qualified by mem_ack |
| mem_rdata | input | 32 | Read data qualified by mem_ack |
| dev_out_valid | output | 1 | Outbound word valid |
| dev_out_ready | input | 1 | Device accepts outbound word |
| dev_out_data | output | 32 | Outbound word |
| dev_in_valid | input | 1 | Inbound word valid |
| dev_in_ready | output | 1 | Engine accepts inbound word |
| dev_in_data | input | 32 | Inbound word |
| dev_irq | input | 1 | Device interrupt |
| irq | output | 1 | Interrupt to host |

## Verification
The zero-count case is the hardest to reach. It needs 16384 inbound words to move through one descriptor before the end-of-table decision happens, and in that same cycle the inbound stream must still offer a word. The bench sets the memory model to a zero-latency acknowledge and has the inbound source offer data without limit. It counts the write acknowledges, records the last write address, and then checks the interrupt flag. The stop and device-interrupt cases are reached by holding the outbound sink not ready, which parks the engine on a word. Software writes then land at a known point in the walk.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DADDR, S_DCNT, S_MRD, S_PUSH, S_PULL, S_MWR
  } seq_st_e;

  localparam logic [2:0] OFF_CMD = 3'd0;
  localparam logic [2:0] OFF_STS = 3'd2;
  localparam logic [2:0] OFF_PTR = 3'd4;

  localparam int CMD_GO    = 0;
  localparam int CMD_TOMEM = 3;
  localparam int STS_ACT   = 0;
  localparam int STS_ERR   = 1;
  localparam int STS_INT   = 2;

  localparam int CNT_W     = 16;
  localparam int LAST_BIT  = 31;
  localparam int WORD_B    = 4;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              hw_err,
  input  logic              hw_int,
  input  logic              dev_irq,
  output logic              go,
  output logic              to_mem,
  output logic [ADDR_W-1:0] tbl_ptr,
  output logic              launch,
  output logic              irq
);
  localparam int PTR_W = ADDR_W - 2;

  logic             go_q, go_d, tomem_q, tomem_d, err_q, err_d, int_q, int_d;
  logic [2:0]       sw_q, sw_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             wr_cmd, wr_sts, wr_ptr;

  always_comb begin
    wr_cmd  = reg_wr && (reg_addr == OFF_CMD);
    wr_sts  = reg_wr && (reg_addr == OFF_STS);
    wr_ptr  = reg_wr && (reg_addr == OFF_PTR);
    go_d    = go_q;
    tomem_d = tomem_q;
    sw_d    = sw_q;
    ptr_d   = ptr_q;
    if (wr_cmd) begin
      go_d    = reg_wdata[CMD_GO];
      tomem_d = reg_wdata[CMD_TOMEM];
    end
    if (wr_sts) sw_d = reg_wdata[7:5];
    if (wr_ptr) ptr_d = reg_wdata[ADDR_W-1:2];
    // hardware set outranks a same-cycle write-one-to-clear
    err_d = hw_err | (err_q & ~(wr_sts & reg_wdata[STS_ERR]));
    int_d = hw_int | dev_irq | (int_q & ~(wr_sts & reg_wdata[STS_INT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      tomem_q <= 1'b0;
      err_q   <= 1'b0;
      int_q   <= 1'b0;
      sw_q    <= '0;
      ptr_q   <= '0;
    end else begin
      go_q    <= go_d;
      tomem_q <= tomem_d;
      err_q   <= err_d;
      int_q   <= int_d;
      sw_q    <= sw_d;
      ptr_q   <= ptr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CMD: begin
        reg_rdata[CMD_GO]    = go_q;
        reg_rdata[CMD_TOMEM] = tomem_q;
      end
      OFF_STS: reg_rdata[7:0] = {sw_q, 2'b00, int_q, err_q, busy};
      OFF_PTR: reg_rdata[ADDR_W-1:0] = {ptr_q, 2'b00};
      default: reg_rdata = '0;
    endcase
  end

  assign launch  = wr_cmd & reg_wdata[CMD_GO] & ~go_q;
  assign go      = go_q;
  assign to_mem  = tomem_q;
  assign tbl_ptr = {ptr_q, 2'b00};
  assign irq     = err_q | int_q;
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              go,
  input  logic              to_mem,
  input  logic [ADDR_W-1:0] tbl_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [31:0]       dev_out_data,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [31:0]       dev_in_data,
  output logic              busy,
  output logic              err_evt,
  output logic              end_int_evt
);
  localparam int                REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0]  FULL  = {1'b1, {CNT_W{1'b0}}};
  localparam logic [REM_W-1:0]  STEPR = REM_W'(WORD_B);
  localparam logic [ADDR_W-1:0] STEPA = ADDR_W'(WORD_B);
  localparam logic [ADDR_W-1:0] DSTEP = ADDR_W'(2 * WORD_B);

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] desc_q, desc_d, buf_q, buf_d;
  logic [REM_W-1:0]  rem_q, rem_d, step, rem_after;
  logic              last_q, last_d, dir_q, dir_d, pend_q, pend_d, abort_q, abort_d;
  logic [31:0]       word_q, word_d;
  logic              stop_now, advance;

  assign stop_now  = abort_q | ~go;
  assign step      = (rem_q > STEPR) ? STEPR : rem_q;
  assign rem_after = rem_q - step;

  assign busy          = (st_q != S_IDLE);
  assign mem_req       = (st_q == S_DADDR) || (st_q == S_DCNT) ||
                         (st_q == S_MRD)   || (st_q == S_MWR);
  assign mem_we        = (st_q == S_MWR);
  assign mem_wdata     = word_q;
  assign dev_out_valid = (st_q == S_PUSH);
  assign dev_out_data  = word_q;
  assign dev_in_ready  = (st_q == S_PULL);

  always_comb begin
    case (st_q)
      S_DADDR: mem_addr = desc_q;
      S_DCNT:  mem_addr = desc_q + STEPA;
      default: mem_addr = buf_q;
    endcase
  end

  always_comb begin
    st_d        = st_q;
    desc_d      = desc_q;
    buf_d       = buf_q;
    rem_d       = rem_q;
    last_d      = last_q;
    dir_d       = dir_q;
    word_d      = word_q;
    pend_d      = launch | (pend_q & go);
    abort_d     = (st_q != S_IDLE) & (abort_q | ~go);
    err_evt     = 1'b0;
    end_int_evt = 1'b0;
    advance     = 1'b0;
    case (st_q)
      S_IDLE: if (pend_q && go) begin
        st_d   = S_DADDR;
        desc_d = tbl_ptr;
        dir_d  = to_mem;
        pend_d = 1'b0;
      end
      S_DADDR: if (mem_ack) begin
        if (mem_err) begin err_evt = 1'b1; st_d = S_IDLE; end
        else if (stop_now) st_d = S_IDLE;
        else begin
          buf_d = {mem_rdata[ADDR_W-1:2], 2'b00};
          st_d  = S_DCNT;
        end
      end
      S_DCNT: if (mem_ack) begin
        if (mem_err) begin err_evt = 1'b1; st_d = S_IDLE; end
        else if (stop_now) st_d = S_IDLE;
        else begin
          rem_d  = (mem_rdata[CNT_W-1:0] == '0) ? FULL : {1'b0, mem_rdata[CNT_W-1:0]};
          last_d = mem_rdata[LAST_BIT];
          desc_d = desc_q + DSTEP;
          st_d   = dir_q ? S_PULL : S_MRD;
        end
      end
      S_MRD: if (mem_ack) begin
        if (mem_err) begin err_evt = 1'b1; st_d = S_IDLE; end
        else begin
          word_d = mem_rdata;
          st_d   = stop_now ? S_IDLE : S_PUSH;
        end
      end
      S_PUSH: begin
        if (stop_now) st_d = S_IDLE;
        else if (dev_out_ready) advance = 1'b1;
      end
      S_PULL: begin
        if (stop_now) st_d = S_IDLE;
        else if (dev_in_valid) begin
          word_d = dev_in_data;
          st_d   = S_MWR;
        end
      end
      S_MWR: if (mem_ack) begin
        if (mem_err) begin err_evt = 1'b1; st_d = S_IDLE; end
        else if (stop_now) st_d = S_IDLE;
        else advance = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
    if (advance) begin
      buf_d = buf_q + STEPA;
      rem_d = rem_after;
      if (rem_after == '0) begin
        if (last_q) begin
          st_d        = S_IDLE;
          end_int_evt = dir_q & dev_in_valid;
        end else begin
          st_d = S_DADDR;
        end
      end else begin
        st_d = dir_q ? S_PULL : S_MRD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      desc_q  <= '0;
      buf_q   <= '0;
      rem_q   <= '0;
      last_q  <= 1'b0;
      dir_q   <= 1'b0;
      word_q  <= '0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      desc_q  <= desc_d;
      buf_q   <= buf_d;
      rem_q   <= rem_d;
      last_q  <= last_d;
      dir_q   <= dir_d;
      word_q  <= word_d;
      pend_q  <= pend_d;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [31:0]       dev_out_data,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [31:0]       dev_in_data,
  input  logic              dev_irq,
  output logic              irq
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  logic                   go, to_mem, launch, busy, err_evt, end_int_evt;
  logic [ADDR_W-1:0]      tbl_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  sgdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .hw_err(err_evt), .hw_int(end_int_evt), .dev_irq(dev_irq),
    .go(go), .to_mem(to_mem), .tbl_ptr(tbl_ptr), .launch(launch), .irq(irq)
  );

  sgdma_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .launch(launch), .go(go), .to_mem(to_mem),
    .tbl_ptr(tbl_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .busy(busy), .err_evt(err_evt),
    .end_int_evt(end_int_evt)
  );
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              dev_out_valid,
  input logic              dev_out_ready,
  input logic [31:0]       dev_out_data,
  input logic              dev_in_ready,
  input logic              dev_irq,
  input logic              irq,
  input logic              go,
  input logic              busy
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_addr_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_out_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready && go |=> dev_out_valid && $stable(dev_out_data));

  assert_dir_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_out_valid && dev_in_ready));

  assert_err_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !busy && irq && !mem_req);

  assert_devirq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |=> irq);
endmodule

bind sgdma_engine sgdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .mem_err(mem_err), .dev_out_valid(dev_out_valid),
  .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
  .dev_in_ready(dev_in_ready), .dev_irq(dev_irq), .irq(irq), .go(go), .busy(busy)
);

// File: tb/sgdma_engine_bench.sv
module sgdma_engine_bench;
  localparam logic [2:0] A_CMD = 3'd0, A_STS = 3'd2, A_PTR = 3'd4;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_out_valid, dev_out_ready, dev_in_valid, dev_in_ready, dev_irq, irq;
  logic [31:0] dev_out_data, dev_in_data;

  sgdma_engine u_sgdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
    .dev_out_data(dev_out_data), .dev_in_valid(dev_in_valid),
    .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
    .dev_irq(dev_irq), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // memory model: mem is written only by tests, wmem only by the responder
  logic [31:0] mem  [0:1023];
  logic [31:0] wmem [0:1023];
  int          mem_lat = 1;
  logic        err_en = 0;
  logic [31:0] err_addr = 0;
  int          lat_cnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0; lat_cnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt >= mem_lat) begin
        lat_cnt = 0;
        mem_ack <= 1'b1;
        mem_err <= err_en && (mem_addr == err_addr);
        if (mem_we) begin
          if (mem_addr < 32'd4096) wmem[mem_addr[11:2]] <= mem_wdata;
        end else begin
          mem_rdata <= (mem_addr < 32'd4096) ? mem[mem_addr[11:2]] : 32'h0;
        end
      end else lat_cnt++;
    end
  end

  // monitors
  int          acc_n = 0, wr_n = 0, req_cyc = 0, sink_n = 0, hs_n = 0;
  logic [31:0] acc_log [0:63];
  logic [31:0] sink [0:63];
  logic [31:0] last_wr = 0;

  always @(posedge clk) begin
    if (mem_req) req_cyc <= req_cyc + 1;
    if (mem_req && mem_ack) begin
      acc_log[acc_n % 64] <= mem_addr;
      acc_n <= acc_n + 1;
      if (mem_we) begin wr_n <= wr_n + 1; last_wr <= mem_addr; end
    end
    if (dev_out_valid && dev_out_ready) begin
      sink[sink_n % 64] <= dev_out_data;
      sink_n <= sink_n + 1;
    end
    if (dev_in_valid && dev_in_ready) hs_n <= hs_n + 1;
  end

  // inbound source
  bit src_inf = 0;
  int src_base = 0, src_lim = 0;
  always @(negedge clk) begin
    dev_in_valid <= src_inf || ((hs_n - src_base) < src_lim);
    dev_in_data  <= 32'hD000_0000 + 32'(hs_n - src_base);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input int lim);
    logic [31:0] v;
    for (int i = 0; i < lim; i++) begin
      rd(A_STS, v);
      if (!v[0]) break;
    end
  endtask

  task automatic load_two_desc_table();
    mem[32'h100 >> 2] = 32'h0000_0402;   // low bits must be ignored
    mem[32'h104 >> 2] = 32'h0000_0008;
    mem[32'h108 >> 2] = 32'h0000_0500;
    mem[32'h10C >> 2] = 32'h8000_0006;   // last, 6 bytes -> 2 words
    mem[32'h400 >> 2] = 32'hA000_0000;
    mem[32'h404 >> 2] = 32'hA000_0001;
    mem[32'h500 >> 2] = 32'hB000_0000;
    mem[32'h504 >> 2] = 32'hB000_0001;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CMD, v); chk("R1 cmd after reset", v, 0);
    rd(A_STS, v); chk("R1 status after reset", v, 0);
    rd(A_PTR, v); chk("R1 pointer after reset", v, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 no request after reset", {31'b0, mem_req}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_PTR, 32'h0000_0103); rd(A_PTR, v); chk("R1 pointer low bits zero", v, 32'h100);
    wr(A_CMD, 32'h0000_000E); rd(A_CMD, v); chk("R1 cmd keeps only bits 0,3", v, 32'h8);
    wr(A_CMD, 32'h0);
  endtask

  task automatic t_to_device();
    logic [31:0] v;
    int ab = acc_n, sb = sink_n;
    load_two_desc_table();
    mem_lat = 1; dev_out_ready = 1'b1;
    wr(A_PTR, 32'h100);
    wr(A_CMD, 32'h1);
    cycles(3);
    rd(A_STS, v); chk("R6 active during walk", v & 32'h1, 1);
    wait_idle(1000);
    rd(A_STS, v); chk("R6 active clear at table end", v, 0);
    chk("R2 first fetch at pointer", acc_log[ab % 64], 32'h100);
    chk("R2 count word at pointer+4", acc_log[(ab + 1) % 64], 32'h104);
    chk("R3 buffer address low bits ignored", acc_log[(ab + 2) % 64], 32'h400);
    chk("R12 consecutive aligned words", acc_log[(ab + 3) % 64], 32'h404);
    chk("R2 next descriptor at +8", acc_log[(ab + 4) % 64], 32'h108);
    chk("R4 word count ceil(N/4)", 32'(sink_n - sb), 4);
    chk("R4 R13 word 0 order", sink[sb % 64], 32'hA000_0000);
    chk("R4 R13 word 1 order", sink[(sb + 1) % 64], 32'hA000_0001);
    chk("R4 R13 word 2 order", sink[(sb + 2) % 64], 32'hB000_0000);
    chk("R4 R13 word 3 order", sink[(sb + 3) % 64], 32'hB000_0001);
    wr(A_CMD, 32'h0);
  endtask

  task automatic t_to_memory();
    logic [31:0] v;
    mem[32'h200 >> 2] = 32'h0000_0600;
    mem[32'h204 >> 2] = 32'h8000_000C;
    mem_lat = 2;
    src_base = hs_n; src_lim = 3;
    wr(A_PTR, 32'h200);
    wr(A_CMD, 32'h9);
    cycles(3);
    wait_idle(1000);
    for (int i = 0; i < 3; i++)
      chk("R5 inbound word written in order", wmem[(32'h600 >> 2) + i], 32'hD000_0000 + 32'(i));
    rd(A_STS, v); chk("R8 stream idle at end leaves int clear", v, 0);
    src_lim = 0;
    wr(A_CMD, 32'h8);
  endtask

  task automatic t_full_count();
    logic [31:0] v;
    int wb = wr_n;
    mem[32'h300 >> 2] = 32'h0000_1000;
    mem[32'h304 >> 2] = 32'h8000_0000;   // count 0 = 65536 bytes, last
    mem_lat = 0;
    src_base = hs_n; src_inf = 1;
    wr(A_PTR, 32'h300);
    wr(A_CMD, 32'h9);
    cycles(3);
    wait_idle(100000);
    chk("R3 zero count moves 16384 words", 32'(wr_n - wb), 32'd16384);
    chk("R3 last write address", last_wr, 32'h0001_0FFC);
    rd(A_STS, v); chk("R8 table end with data pending", v, 32'h4);
    chk("R7 irq follows int flag", {31'b0, irq}, 1);
    src_inf = 0;
    wr(A_STS, 32'h4);
    rd(A_STS, v); chk("R9 write one clears int", v, 0);
    chk("R7 irq low after clear", {31'b0, irq}, 0);
    wr(A_CMD, 32'h0);
    mem_lat = 1;
  endtask

  task automatic t_dev_irq();
    logic [31:0] v;
    int sb = sink_n;
    dev_out_ready = 1'b0;
    wr(A_PTR, 32'h100);
    wr(A_CMD, 32'h1);
    cycles(20);
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    cycles(2);
    rd(A_STS, v); chk("R7 device irq sets int, active kept", v, 32'h5);
    chk("R7 irq output high", {31'b0, irq}, 1);
    wr(A_STS, 32'h4);
    rd(A_STS, v); chk("R9 clear int while active", v, 32'h1);
    dev_out_ready = 1'b1;
    wait_idle(1000);
    rd(A_STS, v); chk("R6 walk completes after irq", v, 0);
    chk("R4 all words delivered", 32'(sink_n - sb), 4);
    wr(A_CMD, 32'h0);
  endtask

  task automatic t_mem_error();
    logic [31:0] v;
    int sb = sink_n, rq;
    dev_out_ready = 1'b1;
    err_addr = 32'h404; err_en = 1'b1;
    wr(A_PTR, 32'h100);
    wr(A_CMD, 32'h1);
    cycles(40);
    rd(A_STS, v); chk("R10 error set, active clear", v, 32'h2);
    chk("R10 irq on error", {31'b0, irq}, 1);
    chk("R10 one word before error", 32'(sink_n - sb), 1);
    rq = req_cyc;
    cycles(20);
    chk("R10 no request after error", 32'(req_cyc - rq), 0);
    err_en = 1'b0;
    wr(A_STS, 32'h2);
    rd(A_STS, v); chk("R9 write one clears error", v, 0);
    wr(A_CMD, 32'h0);
  endtask

  task automatic t_stop_restart();
    logic [31:0] v;
    int sb = sink_n, ab, rq;
    dev_out_ready = 1'b0;
    wr(A_PTR, 32'h100);
    wr(A_CMD, 32'h1);
    cycles(20);
    wr(A_CMD, 32'h0);
    cycles(3);
    rd(A_STS, v); chk("R11 stop clears active", v, 0);
    rq = req_cyc;
    cycles(10);
    chk("R11 no request after stop", 32'(req_cyc - rq), 0);
    chk("R11 no word delivered while stalled", 32'(sink_n - sb), 0);
    ab = acc_n;
    wr(A_CMD, 32'h1);
    cycles(20);
    chk("R11 restart fetches at pointer", acc_log[ab % 64], 32'h100);
    chk("R11 restart reaches first buffer word", acc_log[(ab + 2) % 64], 32'h400);
    chk("R11 restart parked on first word", 32'(acc_n - ab), 3);
    dev_out_ready = 1'b1;
    wait_idle(1000);
    chk("R11 restart delivers whole table", 32'(sink_n - sb), 4);
    chk("R11 restart first word", sink[sb % 64], 32'hA000_0000);
    wr(A_CMD, 32'h0);
  endtask

  task automatic t_sw_bits();
    logic [31:0] v;
    wr(A_STS, 32'hFE);
    rd(A_STS, v); chk("R9 software bits kept, 4:3 read zero", v, 32'hE0);
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    wr(A_STS, 32'hE0);
    rd(A_STS, v); chk("R9 writing zero leaves int set", v, 32'hE4);
    wr(A_STS, 32'hE4);
    rd(A_STS, v); chk("R9 writing one clears int", v, 32'hE0);
    wr(A_STS, 32'h00);
    rd(A_STS, v); chk("R9 software bits cleared", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    dev_out_ready = 1'b0; dev_irq = 1'b0;
    cycles(5);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_regs();
    t_to_device();
    t_to_memory();
    t_full_count();
    t_dev_irq();
    t_mem_error();
    t_stop_restart();
    t_sw_bits();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule